// File: doc/BRIEF.md
# Tick Drift Compensation Scheduler

This block sits between a free-running 32.768 kHz tick source and the seconds prescaler of a calendar clock. It stretches or shrinks the tick stream by a programmed number of tick cycles at three nested calendar points. An hourly correction runs in the final minute of every hour. A daily correction runs in the final minute of the final hour of a day. A monthly correction runs in the final minute of the final hour of the final day of a month. The calendar counter tells the block where it stands through three level indications: final minute, final hour and final day.

Each correction has its own 8-bit trim word. The top bit gives the direction. The low seven bits are a BCD count of tick cycles, stored as the count minus one. Adding time slips extra pulses into idle cycles of the tick stream. Subtracting time deletes real tick pulses. When several corrections fall in the same minute they run one after another, and each one runs at most once per window. The adjusted stream leaves through a single register stage.

Top module: `tick_trim_sched`

## Requirements
- R1: While `rst_n` is low, `tick_out` is 0.
- R2: With `comp_en` low, `tick_out` equals `tick_in` delayed by one clock, whatever the trim words and window inputs are.
- R3: The hourly correction is due only while `in_last_min` is high. The daily correction is due only while `in_last_min` and `in_last_hour` are both high. The monthly correction is due only while all three window inputs are high. Outside its window a correction changes nothing.
- R4: A trim word is decoded as follows: bit 7 is the direction (1 = add, 0 = subtract), bits 6:4 are the BCD tens digit T, and bits 3:0 are the BCD units digit U. The correction length is 10*T + U + 1 tick cycles.
- R5: The trim word 8'h01 means that the level makes no correction.
- R6: When adding, the block emits one extra pulse in each cycle in which `tick_in` is low, until the count is used up. Cycles with `tick_in` high pass through unchanged.
- R7: When subtracting, the block suppresses each `tick_in` pulse, one per cycle, until the count is used up.
- R8: Corrections due in the same minute run in the order hourly, daily, monthly. A level starts only after the level before it has completed.
- R9: Each level applies its correction at most once while its window stays open. A level is armed again after its window closes.
- R10: `tick_out` is the adjusted stream delayed by one clock.
- R11: If the window of the running level closes, or `comp_en` drops, before the count is used up, the correction stops at once. That level is not marked as done, so it runs in full when its window opens again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the raw tick is one cycle wide in this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_en | input | 1 | Global compensation enable |
| tick_in | input | 1 | Raw timebase tick pulse |
| in_last_min | input | 1 | Calendar is in the final minute of the hour |
| in_last_hour | input | 1 | Calendar is in the final hour of the day |
| in_last_day | input | 1 | Calendar is on the final day of the month |
| trim_hour | input | 8 | Hourly trim word |
| trim_day | input | 8 | Daily trim word |
| trim_month | input | 8 | Monthly trim word |
| tick_out | output | 1 | Adjusted tick stream for the seconds prescaler |

## Verification
Every BCD magnitude from 0 to 79, in both directions, is swept on the hourly level with a sparse tick pattern. Counting the output pulses against the input pulses then separates the decode, the off-by-one in the stored count and the direction bit.

A tick held high on every cycle shows that an add finds no idle slot and that a subtract deletes one pulse per cycle. A stream with no ticks at all, combined with a stalled subtract on the daily level, shows whether the monthly level waits for the daily one. A correction cut short by a closing window, followed by a full window, shows the difference between an abort and a completion. Partial window combinations check that each level decodes its own qualifiers.

// File: rtl/tts_pkg.sv
package tts_pkg;
   localparam int NUM_LVL = 3;                 // hourly, daily, monthly
   localparam int IDX_W   = $clog2(NUM_LVL);

   typedef logic [IDX_W-1:0] lvl_idx_t;

   localparam lvl_idx_t LVL_HOUR  = lvl_idx_t'(0);
   localparam lvl_idx_t LVL_DAY   = lvl_idx_t'(1);
   localparam lvl_idx_t LVL_MONTH = lvl_idx_t'(2);
endpackage

// File: rtl/tts_decode.sv
module tts_decode #(
   parameter int TENS_W = 3,
   parameter int ONES_W = 4,
   parameter int CNT_W  = 7,
   localparam int REG_W = 1 + TENS_W + ONES_W
) (
   input  logic [REG_W-1:0] code,
   output logic             is_none,
   output logic             is_add,
   output logic [CNT_W-1:0] cnt
);
   logic [TENS_W-1:0] tens;
   logic [ONES_W-1:0] ones;
   int                len;

   assign tens    = code[TENS_W+ONES_W-1 -: TENS_W];
   assign ones    = code[ONES_W-1:0];
   assign is_add  = code[REG_W-1];
   assign is_none = (code == REG_W'(1));

   always_comb begin
      len = int'(tens) * 10 + int'(ones) + 1;
      cnt = CNT_W'(len);
   end
endmodule

// File: rtl/tts_sched.sv
module tts_sched
   import tts_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en,
   input  logic [NUM_LVL-1:0]             win,
   input  logic [NUM_LVL-1:0]             none_v,
   input  logic [NUM_LVL-1:0]             add_v,
   input  logic [NUM_LVL-1:0][CNT_W-1:0]  cnt_v,
   input  logic                           eng_finish,
   output logic                           load,
   output logic                           load_add,
   output logic [CNT_W-1:0]               load_cnt,
   output logic                           abort,
   output logic                           running
);
   logic [NUM_LVL-1:0] done_q, done_nx, due;
   lvl_idx_t           sel, cur_q;
   logic               sel_ok, skip;

   // lowest index wins: hourly before daily before monthly
   always_comb begin
      due    = win & ~done_q & {NUM_LVL{en}};
      sel_ok = 1'b0;
      sel    = LVL_HOUR;
      for (int i = NUM_LVL - 1; i >= 0; i--) begin
         if (due[i]) begin
            sel_ok = 1'b1;
            sel    = lvl_idx_t'(i);
         end
      end
   end

   assign skip     = !running && sel_ok && none_v[sel];
   assign load     = !running && sel_ok && !none_v[sel];
   assign load_add = add_v[sel];
   assign load_cnt = cnt_v[sel];
   assign abort    = running && (!en || !win[cur_q]);

   always_comb begin
      done_nx = done_q & win;      // a closed window re-arms its level
      if (skip)
         done_nx[sel] = 1'b1;
      if (running && eng_finish)
         done_nx[cur_q] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= '0;
         running <= 1'b0;
         cur_q   <= LVL_HOUR;
      end else begin
         done_q <= done_nx;
         if (abort || (running && eng_finish)) begin
            running <= 1'b0;
         end else if (load) begin
            running <= 1'b1;
            cur_q   <= sel;
         end
      end
   end
endmodule

// File: rtl/tts_engine.sv
module tts_engine #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_add,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             abort,
   input  logic             tick_in,
   output logic             tick_mod,
   output logic             finish,
   output logic             busy
);
   logic [CNT_W-1:0] rem_q;
   logic             add_q, act, step;

   assign act      = busy && !abort;
   assign step     = act && (add_q ? !tick_in : tick_in);
   assign tick_mod = add_q ? (tick_in | step) : (tick_in & !step);
   assign finish   = step && (rem_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         add_q <= 1'b0;
         rem_q <= '0;
      end else if (load) begin
         busy  <= 1'b1;
         add_q <= load_add;
         rem_q <= load_cnt;
      end else if (abort || finish) begin
         busy  <= 1'b0;
         rem_q <= '0;
      end else if (step) begin
         rem_q <= rem_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/tick_trim_sched.sv
module tick_trim_sched
   import tts_pkg::*;
#(
   parameter int TENS_W = 3,
   parameter int ONES_W = 4,
   localparam int REG_W   = 1 + TENS_W + ONES_W,
   localparam int MAX_CNT = (2**TENS_W - 1) * 10 + (2**ONES_W - 1) + 1,
   localparam int CNT_W   = $clog2(MAX_CNT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             comp_en,
   input  logic             tick_in,
   input  logic             in_last_min,
   input  logic             in_last_hour,
   input  logic             in_last_day,
   input  logic [REG_W-1:0] trim_hour,
   input  logic [REG_W-1:0] trim_day,
   input  logic [REG_W-1:0] trim_month,
   output logic             tick_out
);
   if (TENS_W < 1 || TENS_W > 4) begin : g_bad_tens
      $error("tick_trim_sched: TENS_W must be 1..4");
   end
   if (ONES_W != 4) begin : g_bad_ones
      $error("tick_trim_sched: ONES_W must be 4 for a BCD units digit");
   end

   logic [NUM_LVL-1:0][REG_W-1:0] trim_v;
   logic [NUM_LVL-1:0]            win, none_v, add_v;
   logic [NUM_LVL-1:0][CNT_W-1:0] cnt_v;
   logic                          load, load_add, abort, sched_run;
   logic                          eng_busy, eng_finish, tick_mod;
   logic [CNT_W-1:0]              load_cnt;

   assign trim_v[LVL_HOUR]  = trim_hour;
   assign trim_v[LVL_DAY]   = trim_day;
   assign trim_v[LVL_MONTH] = trim_month;

   // nested windows: each level adds one qualifier to the previous one
   assign win[LVL_HOUR]  = in_last_min;
   assign win[LVL_DAY]   = in_last_min & in_last_hour;
   assign win[LVL_MONTH] = in_last_min & in_last_hour & in_last_day;

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_dec
      tts_decode #(.TENS_W(TENS_W), .ONES_W(ONES_W), .CNT_W(CNT_W)) u_dec (
         .code    (trim_v[g]),
         .is_none (none_v[g]),
         .is_add  (add_v[g]),
         .cnt     (cnt_v[g])
      );
   end

   tts_sched #(.CNT_W(CNT_W)) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (comp_en),
      .win        (win),
      .none_v     (none_v),
      .add_v      (add_v),
      .cnt_v      (cnt_v),
      .eng_finish (eng_finish),
      .load       (load),
      .load_add   (load_add),
      .load_cnt   (load_cnt),
      .abort      (abort),
      .running    (sched_run)
   );

   tts_engine #(.CNT_W(CNT_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_add (load_add),
      .load_cnt (load_cnt),
      .abort    (abort),
      .tick_in  (tick_in),
      .tick_mod (tick_mod),
      .finish   (eng_finish),
      .busy     (eng_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_out <= 1'b0;
      else        tick_out <= tick_mod;
   end
endmodule

// File: rtl/tts_checker.sv
module tts_checker (
   input logic clk,
   input logic rst_n,
   input logic comp_en,
   input logic tick_in,
   input logic in_last_min,
   input logic tick_out,
   input logic sched_run,
   input logic eng_busy
);
   // R1: output quiet while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (tick_out == 1'b0)
            else $error("R1: tick_out high in reset");
      end
   end

   a_r2_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_en |=> (tick_out == $past(tick_in)))
      else $error("R2: stream altered while disabled");

   a_r3_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
      !in_last_min |=> (tick_out == $past(tick_in)))
      else $error("R3: stream altered outside window");

   a_r8_sched_engine_agree: assert property (@(posedge clk) disable iff (!rst_n)
      sched_run == eng_busy)
      else $error("R8: scheduler and engine disagree");

   a_r11_stop_on_close: assert property (@(posedge clk) disable iff (!rst_n)
      (sched_run && !in_last_min) |=> !eng_busy)
      else $error("R11: engine still busy after window closed");
endmodule

bind tick_trim_sched tts_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .comp_en     (comp_en),
   .tick_in     (tick_in),
   .in_last_min (in_last_min),
   .tick_out    (tick_out),
   .sched_run   (sched_run),
   .eng_busy    (eng_busy)
);

// File: tb/tb_tick_trim_sched.sv
`timescale 1ns/1ps
module tb_tick_trim_sched;
   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       comp_en = 1'b0;
   logic       tick_in = 1'b0;
   logic       in_last_min = 1'b0, in_last_hour = 1'b0, in_last_day = 1'b0;
   logic [7:0] trim_hour = 8'h01, trim_day = 8'h01, trim_month = 8'h01;
   logic       tick_out;

   int nchk = 0;
   int nerr = 0;

   always #2 clk = ~clk;   // 250 MHz

   tick_trim_sched dut (
      .clk(clk), .rst_n(rst_n), .comp_en(comp_en), .tick_in(tick_in),
      .in_last_min(in_last_min), .in_last_hour(in_last_hour),
      .in_last_day(in_last_day), .trim_hour(trim_hour), .trim_day(trim_day),
      .trim_month(trim_month), .tick_out(tick_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // mode 0: no ticks, 1: tick every 4th cycle, 2: tick every cycle
   task automatic run_win(input logic lm, input logic lh, input logic ld,
                          input int w, input int mode,
                          output int nin, output int nout);
      nin = 0;
      nout = 0;
      for (int j = 0; j < w; j++) begin
         @(negedge clk);
         nout += int'(tick_out);
         in_last_min  = lm;
         in_last_hour = lh;
         in_last_day  = ld;
         tick_in = (mode == 2) || (mode == 1 && (j % 4) == 0);
         nin += int'(tick_in);
      end
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         nout += int'(tick_out);
         in_last_min  = 1'b0;
         in_last_hour = 1'b0;
         in_last_day  = 1'b0;
         tick_in      = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int nin, nout, exp_len, delta;
      #1 rst_n = 1'b0;
      // R1: tick_out stays low through reset while tick_in toggles
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R1 reset output", int'(tick_out), 0);
         tick_in = ~tick_in;
      end
      tick_in = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: disabled, add request ignored
      trim_hour = 8'h85;
      run_win(1, 1, 1, 200, 1, nin, nout);
      chk("R2 disabled passthru", nout, nin);

      comp_en = 1'b1;

      // R4/R5/R6/R7/R10: sweep all BCD magnitudes, both directions, hourly level
      for (int dir = 0; dir < 2; dir++) begin
         for (int t = 0; t < 8; t++) begin
            for (int u = 0; u < 10; u++) begin
               trim_hour = {dir[0], t[2:0], u[3:0]};
               exp_len = t * 10 + u + 1;
               if (trim_hour == 8'h01) delta = 0;           // R5
               else if (dir == 1)      delta = exp_len;     // R6
               else                    delta = -exp_len;    // R7
               run_win(1, 0, 0, 400, 1, nin, nout);
               chk("R4 sweep decode/direction", nout, nin + delta);
            end
         end
      end

      // R5: 8'h01 no correction; R4: 8'h81 adds 2
      trim_hour = 8'h01;
      run_win(1, 0, 0, 400, 1, nin, nout);
      chk("R5 no-comp code", nout, nin);
      trim_hour = 8'h81;
      run_win(1, 0, 0, 400, 1, nin, nout);
      chk("R4 add code 0x81", nout, nin + 2);

      // R6: no idle slot -> add has no effect
      trim_hour = 8'h84;
      run_win(1, 0, 0, 400, 2, nin, nout);
      chk("R6 add without idle slots", nout, nin);
      // R7: one swallow per cycle with continuous ticks
      trim_hour = 8'h09;
      run_win(1, 0, 0, 400, 2, nin, nout);
      chk("R7 swallow continuous", nout, nin - 10);

      // R3: window qualifiers per level
      trim_hour = 8'h01; trim_day = 8'h83; trim_month = 8'h01;
      run_win(1, 0, 1, 400, 1, nin, nout);
      chk("R3 daily needs last hour", nout, nin);
      run_win(1, 1, 0, 400, 1, nin, nout);
      chk("R3 daily applied", nout, nin + 4);
      trim_day = 8'h01; trim_month = 8'h86;
      run_win(1, 1, 0, 400, 1, nin, nout);
      chk("R3 monthly needs last day", nout, nin);
      run_win(0, 1, 1, 400, 1, nin, nout);
      chk("R3 monthly needs last minute", nout, nin);
      run_win(1, 1, 1, 400, 1, nin, nout);
      chk("R3 monthly applied", nout, nin + 7);

      // R8: all three levels in one minute, mixed directions: +12 -20 +7
      trim_hour = 8'h91; trim_day = 8'h19; trim_month = 8'h86;
      run_win(1, 1, 1, 1200, 1, nin, nout);
      chk("R8 combined levels", nout, nin - 1);
      // R8: a stalled daily subtract (no ticks) blocks the monthly add
      trim_hour = 8'h82; trim_day = 8'h05; trim_month = 8'h84;
      run_win(1, 1, 1, 600, 0, nin, nout);
      chk("R8 order hourly-daily-monthly", nout, 3);

      // R9: long window applies once; reopening re-arms
      trim_hour = 8'h84; trim_day = 8'h01; trim_month = 8'h01;
      run_win(1, 0, 0, 1500, 1, nin, nout);
      chk("R9 once per window", nout, nin + 5);
      run_win(1, 0, 0, 400, 1, nin, nout);
      chk("R9 re-armed after close", nout, nin + 5);

      // R11: short window aborts a subtract of 50 after 9 swallows
      trim_hour = 8'h49;
      run_win(1, 0, 0, 40, 1, nin, nout);
      chk("R11 abort on close", nout, nin - 9);
      run_win(1, 0, 0, 400, 1, nin, nout);
      chk("R11 full run after abort", nout, nin - 50);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule